// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Sequencer

This block loads a 24-bit control word into an external programmable frequency synthesizer over two bit-banged lines, a serial clock and a serial data line. A one-cycle start pulse captures the word. The block then drives a fixed wake-up preamble. Next it sends each of the 24 bits, least significant first, as four line states: first the complement of the bit, then the bit itself. A short fixed trailer follows. The lines then go back to their rest levels. The block waits a settle interval, because the synthesizer output is not trusted until that interval has passed, and then pulses done.

The word comes either straight from `word_in` or from a packing stage that builds it from divider fields. The output of the synthesizer is reference × P / Q / 2^M. The packer stores P and Q with fixed offsets subtracted, and adds the post-divider M, a VCO band index and a register-select field. A run-time hold length sets how many system clocks each line state lasts. That hold has a floor of four clocks, so the external device always sees enough setup and hold time.

Top module: `synth_prog`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, `syn_clk` rests at IDLE_CLK (default 0) and `syn_data` rests at IDLE_DAT (default 1). In the same conditions `busy` and `done` are 0. A reset in the middle of a frame returns the lines to these levels at once.
- R2: A `start` pulse seen at a clock edge while idle raises `busy` at that edge and presents line state 0 at the same edge. `busy` stays high until the frame ends.
- R3: The frame opens with 17 states, given here as (data, clock). States 0 to 11 have data 1, with the clock at 0 in even states and 1 in odd states. States 12 to 16 are (1,0), (0,0), (0,1), (0,0), (0,1).
- R4: Data bit b of word bit i, for i from 0 to 23 and least significant first, takes frame states 17+4i to 20+4i. Those four states are (not b, 1), (not b, 0), (b, 0), (b, 1).
- R5: States 113 to 115 are (1,1), (1,0), (1,1). From the next hold period onward, the lines are back at the R1 rest levels.
- R6: Every line state lasts exactly H system clocks. H is `hold_len` sampled at start, with any value below 4 raised to 4.
- R7: After the last trailer state, `busy` stays high for SETTLE_CYCLES clocks with the lines at rest. At the end of that time `busy` falls and `done` is 1 for exactly one cycle.
- R8: A `start` that arrives while `busy` is high has no effect. The frame in progress keeps its word and its timing, and no second frame follows it.
- R9: With `use_fields` = 1, the word sent is built as follows. Bits 6:0 hold Q−2, bits 9:7 hold M, bits 16:10 hold P−3, bits 20:17 hold the band index, and bits 23:21 hold the register select. With `use_fields` = 0, the word sent is `word_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to program the synthesizer |
| use_fields | input | 1 | 1: send the packed divider fields; 0: send word_in |
| word_in | input | 24 | Raw control word |
| p_div | input | 8 | Feedback divider P (4 to 130) |
| q_div | input | 7 | Reference divider Q (14 to 71) |
| m_div | input | 3 | Post-divider exponent M |
| vco_band | input | 4 | VCO band index |
| reg_sel | input | 3 | Target register select |
| hold_len | input | 8 | System clocks per line state (floor of 4) |
| syn_clk | output | 1 | Serial clock line to the synthesizer |
| syn_data | output | 1 | Serial data line to the synthesizer |
| busy | output | 1 | Frame or settle interval in progress |
| done | output | 1 | One-cycle pulse when the new setting is valid |

## Verification
The bound checker watches, on every cycle, the rules that concern a single cycle or a pair of cycles. It checks that the lines move only at a hold-period step or at start acceptance, and that both lines sit at rest whenever `busy` is low. It also checks that `busy` rises only after a start, that `done` is one cycle wide and coincides with `busy` falling, and that the captured word does not change when a start arrives during a frame. The exact content of the preamble, of the per-bit encoding and of the trailer, the word rebuilt from the line waveform, the hold-length floor and the settle length can only be shown by the bench's frame scenarios. The bench samples every state twice per hold period for those scenarios.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int CW_W     = 24;
  localparam int PRE_LEN  = 17;
  localparam int STOP_LEN = 3;
  localparam int MIN_HOLD = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_BITS,
    SQ_STOP,
    SQ_SETTLE
  } seq_phase_t;

  typedef struct packed {
    logic ln_d;
    logic ln_c;
  } line_t;

  // Wake-up preamble: alternating clock with data high, then a data-low tail.
  function automatic line_t pre_line(input logic [4:0] idx);
    line_t l;
    if (idx < 5'd13) begin
      l.ln_d = 1'b1;
      l.ln_c = idx[0];
    end else begin
      l.ln_d = 1'b0;
      l.ln_c = ~idx[0];
    end
    return l;
  endfunction

  // One data bit: complement first, then true value; clock high at both ends.
  function automatic line_t bit_line(input logic b, input logic [1:0] sub);
    line_t l;
    l.ln_d = sub[1] ? b : ~b;
    l.ln_c = (sub == 2'd0) || (sub == 2'd3);
    return l;
  endfunction

  // Trailer: data high, clock high-low-high.
  function automatic line_t stop_line(input logic [4:0] idx);
    line_t l;
    l.ln_d = 1'b1;
    l.ln_c = (idx != 5'd1);
    return l;
  endfunction

  // Biased divider packing.
  function automatic logic [CW_W-1:0] pack_ctl(input logic [7:0] p,
                                               input logic [6:0] q,
                                               input logic [2:0] m,
                                               input logic [3:0] band,
                                               input logic [2:0] sel);
    logic [7:0] p_b;
    logic [6:0] q_b;
    p_b = p - 8'd3;
    q_b = q - 7'd2;
    return {sel, band, p_b[6:0], m, q_b};
  endfunction

endpackage

// File: rtl/synth_prog_pack.sv
module synth_prog_pack
  import synth_prog_pkg::*;
(
  input  logic            use_fields,
  input  logic [CW_W-1:0] word_in,
  input  logic [7:0]      p_div,
  input  logic [6:0]      q_div,
  input  logic [2:0]      m_div,
  input  logic [3:0]      vco_band,
  input  logic [2:0]      reg_sel,
  output logic [CW_W-1:0] word_out
);

  logic [CW_W-1:0] packed_word;

  always_comb begin
    packed_word = pack_ctl(p_div, q_div, m_div, vco_band, reg_sel);
    word_out    = use_fields ? packed_word : word_in;
  end

endmodule

// File: rtl/synth_prog_timer.sv
module synth_prog_timer
  import synth_prog_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              run,
  output logic              tick
);

  localparam logic [HOLD_W-1:0] HOLD_FLOOR = HOLD_W'(MIN_HOLD);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] cnt_q;

  assign tick = run && (cnt_q == hold_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_FLOOR;
      cnt_q  <= '0;
    end else if (load) begin
      hold_q <= (hold_len < HOLD_FLOOR) ? HOLD_FLOOR : hold_len;
      cnt_q  <= '0;
    end else if (run) begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int   SETTLE_CYCLES = 25_000_000,
  parameter logic IDLE_CLK      = 1'b0,
  parameter logic IDLE_DAT      = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW_W-1:0] word,
  input  logic            tick,
  output logic            shifting,
  output logic            accept,
  output logic            step,
  output logic [CW_W-1:0] cap_word,
  output logic            busy,
  output logic            done,
  output logic            line_c,
  output logic            line_d
);

  localparam int BIT_W = $clog2(CW_W);
  localparam int SET_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

  seq_phase_t       phase_q, phase_n;
  logic [4:0]       idx_q, idx_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [1:0]       sub_q, sub_n;
  logic [SET_W-1:0] set_q, set_n;
  logic             done_n;
  line_t            line_n;

  assign busy     = (phase_q != SQ_IDLE);
  assign shifting = (phase_q == SQ_PRE) || (phase_q == SQ_BITS) || (phase_q == SQ_STOP);
  assign accept   = start && (phase_q == SQ_IDLE);
  assign step     = tick && shifting;

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    bit_n   = bit_q;
    sub_n   = sub_q;
    set_n   = set_q;
    done_n  = 1'b0;
    unique case (phase_q)
      SQ_IDLE: begin
        if (start) begin
          phase_n = SQ_PRE;
          idx_n   = '0;
        end
      end
      SQ_PRE: begin
        if (tick) begin
          if (idx_q == 5'(PRE_LEN - 1)) begin
            phase_n = SQ_BITS;
            bit_n   = '0;
            sub_n   = '0;
          end else begin
            idx_n = idx_q + 5'd1;
          end
        end
      end
      SQ_BITS: begin
        if (tick) begin
          if (sub_q == 2'd3) begin
            sub_n = '0;
            if (bit_q == BIT_W'(CW_W - 1)) begin
              phase_n = SQ_STOP;
              idx_n   = '0;
            end else begin
              bit_n = bit_q + 1'b1;
            end
          end else begin
            sub_n = sub_q + 2'd1;
          end
        end
      end
      SQ_STOP: begin
        if (tick) begin
          if (idx_q == 5'(STOP_LEN - 1)) begin
            phase_n = SQ_SETTLE;
            set_n   = '0;
          end else begin
            idx_n = idx_q + 5'd1;
          end
        end
      end
      SQ_SETTLE: begin
        if (set_q == SET_W'(SETTLE_CYCLES - 1)) begin
          phase_n = SQ_IDLE;
          done_n  = 1'b1;
        end else begin
          set_n = set_q + 1'b1;
        end
      end
      default: phase_n = SQ_IDLE;
    endcase
  end

  always_comb begin
    line_n.ln_d = IDLE_DAT;
    line_n.ln_c = IDLE_CLK;
    unique case (phase_n)
      SQ_PRE:  line_n = pre_line(idx_n);
      SQ_BITS: line_n = bit_line(cap_word[bit_n], sub_n);
      SQ_STOP: line_n = stop_line(idx_n);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= SQ_IDLE;
      idx_q    <= '0;
      bit_q    <= '0;
      sub_q    <= '0;
      set_q    <= '0;
      done     <= 1'b0;
      cap_word <= '0;
      line_c   <= IDLE_CLK;
      line_d   <= IDLE_DAT;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      bit_q   <= bit_n;
      sub_q   <= sub_n;
      set_q   <= set_n;
      done    <= done_n;
      line_c  <= line_n.ln_c;
      line_d  <= line_n.ln_d;
      if (accept) cap_word <= word;
    end
  end

endmodule

// File: rtl/synth_prog.sv
module synth_prog
  import synth_prog_pkg::*;
#(
  parameter int   HOLD_W        = 8,
  parameter int   SETTLE_CYCLES = 25_000_000,
  parameter logic IDLE_CLK      = 1'b0,
  parameter logic IDLE_DAT      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_fields,
  input  logic [CW_W-1:0]   word_in,
  input  logic [7:0]        p_div,
  input  logic [6:0]        q_div,
  input  logic [2:0]        m_div,
  input  logic [3:0]        vco_band,
  input  logic [2:0]        reg_sel,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              syn_clk,
  output logic              syn_data,
  output logic              busy,
  output logic              done
);

  logic [CW_W-1:0] word_sel;
  logic [CW_W-1:0] cap_word;
  logic            shifting;
  logic            accept_evt;
  logic            step_evt;
  logic            tick;

  synth_prog_pack u_pack (
    .use_fields (use_fields),
    .word_in    (word_in),
    .p_div      (p_div),
    .q_div      (q_div),
    .m_div      (m_div),
    .vco_band   (vco_band),
    .reg_sel    (reg_sel),
    .word_out   (word_sel)
  );

  synth_prog_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .hold_len (hold_len),
    .run      (shifting),
    .tick     (tick)
  );

  synth_prog_seq #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .IDLE_CLK      (IDLE_CLK),
    .IDLE_DAT      (IDLE_DAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .word     (word_sel),
    .tick     (tick),
    .shifting (shifting),
    .accept   (accept_evt),
    .step     (step_evt),
    .cap_word (cap_word),
    .busy     (busy),
    .done     (done),
    .line_c   (syn_clk),
    .line_d   (syn_data)
  );

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk #(
  parameter int   CW_W     = 24,
  parameter logic IDLE_CLK = 1'b0,
  parameter logic IDLE_DAT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            syn_clk,
  input logic            syn_data,
  input logic            step_evt,
  input logic            accept_evt,
  input logic [CW_W-1:0] cap_word
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (syn_clk == IDLE_CLK && syn_data == IDLE_DAT));

  // R6
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({syn_clk, syn_data}) |-> $past(step_evt || accept_evt));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cap_word));

endmodule

bind synth_prog synth_prog_chk #(
  .CW_W     (synth_prog_pkg::CW_W),
  .IDLE_CLK (IDLE_CLK),
  .IDLE_DAT (IDLE_DAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .syn_clk    (syn_clk),
  .syn_data   (syn_data),
  .step_evt   (step_evt),
  .accept_evt (accept_evt),
  .cap_word   (cap_word)
);

// File: tb/synth_prog_bench.sv
`timescale 1ns/1ps
module synth_prog_bench;

  localparam int S      = 20;
  localparam int NSTATE = 116;
  localparam int NV     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        use_fields = 1'b0;
  logic [23:0] word_in = '0;
  logic [7:0]  p_div = 8'd4;
  logic [6:0]  q_div = 7'd14;
  logic [2:0]  m_div = '0;
  logic [3:0]  vco_band = '0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  hold_len = 8'd4;
  logic        syn_clk, syn_data, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  synth_prog #(.SETTLE_CYCLES(S)) u_synth_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .use_fields(use_fields),
    .word_in(word_in), .p_div(p_div), .q_div(q_div), .m_div(m_div),
    .vco_band(vco_band), .reg_sel(reg_sel), .hold_len(hold_len),
    .syn_clk(syn_clk), .syn_data(syn_data), .busy(busy), .done(done)
  );

  // Stimulus vectors: use_fields, raw word, P, Q, M, band, select, hold
  localparam logic        V_USE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [23:0] V_WRD [NV] = '{24'hA5C33C, 24'h000001, 24'h0, 24'hFFFFFF, 24'h0};
  localparam logic [7:0]  V_P   [NV] = '{8'd4, 8'd4, 8'd130, 8'd4, 8'd4};
  localparam logic [6:0]  V_Q   [NV] = '{7'd14, 7'd14, 7'd71, 7'd14, 7'd14};
  localparam logic [2:0]  V_M   [NV] = '{3'd0, 3'd0, 3'd7, 3'd0, 3'd0};
  localparam logic [3:0]  V_B   [NV] = '{4'd0, 4'd0, 4'd13, 4'd0, 4'd0};
  localparam logic [2:0]  V_S   [NV] = '{3'd0, 3'd0, 3'd2, 3'd0, 3'd5};
  localparam logic [7:0]  V_H   [NV] = '{8'd4, 8'd1, 8'd6, 8'd5, 8'd0};
  localparam bit          V_INJ [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  // Expected preamble (bit k = state k) and trailer
  localparam logic [16:0] PRE_D = 17'b0_0001_1111_1111_1111;
  localparam logic [16:0] PRE_C = 17'b1_0100_1010_1010_1010;
  localparam logic [2:0]  STP_C = 3'b101;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_word(input logic use_f, input logic [23:0] w,
                                     input int p, input int q, input int m,
                                     input int b, input int s);
    if (!use_f) return int'(w);
    return (q - 2) + m * 128 + (p - 3) * 1024 + b * 131072 + s * 2097152;
  endfunction

  task automatic run_frame(input int v);
    logic d_early [NSTATE];
    logic c_early [NSTATE];
    int   h, exp_w, got_w, pre_bad, enc_bad, stp_bad, hold_bad, busy_bad;
    h = (V_H[v] < 4) ? 4 : int'(V_H[v]);
    exp_w = expect_word(V_USE[v], V_WRD[v], V_P[v], V_Q[v], V_M[v], V_B[v], V_S[v]);
    pre_bad = 0; enc_bad = 0; stp_bad = 0; hold_bad = 0; busy_bad = 0; got_w = 0;
    use_fields = V_USE[v]; word_in = V_WRD[v]; p_div = V_P[v]; q_div = V_Q[v];
    m_div = V_M[v]; vco_band = V_B[v]; reg_sel = V_S[v]; hold_len = V_H[v];
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < NSTATE; k++) begin
      d_early[k] = syn_data;
      c_early[k] = syn_clk;
      if (!busy) busy_bad++;
      if (V_INJ[v] && k == 40) begin
        start = 1'b1; use_fields = 1'b0; word_in = ~V_WRD[v]; hold_len = 8'd9;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (h - 2) @(posedge clk);
        #1;
      end else begin
        repeat (h - 1) @(posedge clk);
        #1;
      end
      if (syn_data != d_early[k] || syn_clk != c_early[k]) hold_bad++;
      @(posedge clk); #1;
    end
    for (int k = 0; k < 17; k++)
      if (d_early[k] != PRE_D[k] || c_early[k] != PRE_C[k]) pre_bad++;
    for (int i = 0; i < 24; i++) begin
      logic b;
      b = d_early[17 + 4*i + 2];
      if (d_early[17+4*i] != ~b || d_early[18+4*i] != ~b || d_early[20+4*i] != b) enc_bad++;
      if (c_early[17+4*i] != 1'b1 || c_early[18+4*i] != 1'b0 ||
          c_early[19+4*i] != 1'b0 || c_early[20+4*i] != 1'b1) enc_bad++;
      got_w = got_w | (int'(b) << i);
    end
    for (int k = 0; k < 3; k++)
      if (d_early[113+k] != 1'b1 || c_early[113+k] != STP_C[k]) stp_bad++;
    check(pre_bad == 0, "R3 preamble states", pre_bad, 0);
    check(enc_bad == 0, "R4 per-bit four-state encoding", enc_bad, 0);
    check(got_w == exp_w, V_USE[v] ? "R9 packed word rebuilt" :
          (V_INJ[v] ? "R8 word kept despite start while busy" : "R4 word rebuilt"),
          got_w, exp_w);
    check(stp_bad == 0, "R5 trailer states", stp_bad, 0);
    check(hold_bad == 0, "R6 hold length per state", hold_bad, 0);
    check(busy_bad == 0, "R2 busy during frame", busy_bad, 0);
    check(syn_clk == 1'b0 && syn_data == 1'b1 && busy,
          "R5 rest levels after trailer", {syn_data, syn_clk, busy}, 3'b101);
    repeat (S - 1) @(posedge clk);
    #1;
    check(busy && !done, "R7 still settling", {busy, done}, 2'b10);
    @(posedge clk); #1;
    check(!busy && done, "R7 done at settle end", {busy, done}, 2'b01);
    @(posedge clk); #1;
    check(!done, "R7 done one cycle", done, 0);
    if (V_INJ[v]) begin
      int seen;
      seen = 0;
      repeat (40) begin
        @(posedge clk); #1;
        if (busy) seen++;
      end
      check(seen == 0, "R8 no second frame", seen, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    check(syn_clk == 1'b0 && syn_data == 1'b1 && !busy && !done,
          "R1 reset state", {syn_data, syn_clk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(syn_clk == 1'b0 && syn_data == 1'b1 && !busy,
          "R1 idle after reset", {syn_data, syn_clk, busy}, 3'b100);

    for (int v = 0; v < NV; v++) run_frame(v);

    // Directed: reset in the middle of a frame
    use_fields = 1'b0; word_in = 24'h123456; hold_len = 8'd4; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy, "R2 busy right after start", busy, 1);
    repeat (30) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(syn_clk == 1'b0 && syn_data == 1'b1 && !busy && !done,
          "R1 mid-frame reset", {syn_data, syn_clk, busy, done}, 4'b1000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(!busy, "R1 stays idle after reset", busy, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule